// File: doc/BRIEF.md
# External Interrupt Pin Sense Unit

This block takes eight asynchronous external interrupt pins and turns each into an active-high level request for a parent interrupt controller. Every pin is brought into the clock domain through a two-flop synchroniser. It is then judged against a per-pin 2-bit sense code: active-low level, falling edge, rising edge or either edge. In the three edge modes a detected edge sets a sticky status bit. In the level mode the status bit simply mirrors the inverted pin.

Software reaches the block through a plain 32-bit register bus with separate write and read strobes. It selects the sense code of each pin, reads and clears the status bits, and masks individual requests. A request leaves the block only while its status bit is set and its mask bit is clear. The register bus is a control path with no data stream, so it has no valid/ready handshake. A write lands on the clock edge where its strobe is high. A read returns data on `bus_rdata` one cycle after its strobe.

Top module: `pin_sense_unit`

## Requirements
- R1: Each of the eight pins passes through two synchronising flops. A pin change driven before clock edge k appears on the status bit, and on the request, just after edge k+2 and not earlier.
- R2: The sense register at byte offset 0x14 holds a 2-bit code for pin n in bits [2n+1:2n]. It reads back what was written, and bits 31:16 read as zero.
- R3: Sense code 0 (active-low level): the status bit equals the inverse of the synchronised pin. It sets while the pin is low and drops when the pin returns high.
- R4: Sense code 1 (falling edge): a 1-to-0 pin transition sets the status bit. A 0-to-1 transition leaves it unchanged.
- R5: Sense code 2 (rising edge): a 0-to-1 pin transition sets the status bit. A 1-to-0 transition leaves it unchanged.
- R6: Sense code 3 (both edges): either transition sets the status bit.
- R7: The status register at byte offset 0x10 holds bit n for pin n. In an edge mode (code 1, 2 or 3), writing 0 to a bit clears it, and writing 1 to a bit leaves it unchanged.
- R8: In sense code 0, a status write of 0 has no effect. The bit keeps following the pin.
- R9: If a status clear write and a newly detected edge on the same pin land on the same clock edge, the status bit stays set.
- R10: The mask register at byte offset 0x10010 holds bit n for pin n. The request for pin n is high exactly when its status bit is 1 and its mask bit is 0.
- R11: Reset clears all sense codes, status bits, mask bits and requests. The synchroniser flops reset to the idle-high pin level, so no event is seen right after reset.
- R12: A read strobe returns the addressed register on `bus_rdata` after the next clock edge. Any address other than the three registers reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Asynchronous external interrupt pins |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 20 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, valid the cycle after `bus_rd` |
| irq_req_o | output | 8 | Active-high level requests to the parent controller |

## Verification
The hardest case to reach from the ports is a software clear and a fresh edge landing on the same clock edge. The edge reaches the status logic two synchroniser stages after the pin moves, so the stimulus toggles the pin in both-edge mode and issues the clear write exactly two cycles later. A second clear with no edge pending confirms that the bit really is clearable. The rest of the stimulus sweeps every pin through every sense code and both pin transitions, with a clear after each step. It also sweeps all 256 mask patterns while every status bit is held set.

// File: rtl/psu_pkg.sv
package psu_pkg;

  typedef enum logic [1:0] {
    SENSE_LVL_LOW = 2'd0,
    SENSE_FALL    = 2'd1,
    SENSE_RISE    = 2'd2,
    SENSE_BOTH    = 2'd3
  } sense_e;

  localparam int unsigned OFS_STATUS = 32'h0001_0 >> 0;
  localparam int unsigned OFS_SENSE  = 32'h0000_0014;
  localparam int unsigned OFS_MASK   = 32'h0001_0010;

endpackage

// File: rtl/psu_sync.sv
module psu_sync #(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o,
  output logic q_prev_o
);

  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= IDLE_LVL;
      q_o      <= IDLE_LVL;
      q_prev_o <= IDLE_LVL;
    end else begin
      meta_q   <= d_i;
      q_o      <= meta_q;
      q_prev_o <= q_o;
    end
  end

endmodule

// File: rtl/psu_lane.sv
module psu_lane
  import psu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sync_now,
  input  logic   sync_prev,
  input  sense_e mode_i,
  input  logic   clr_i,
  output logic   status_o
);

  logic rise, fall, evt, is_edge, status_nxt;

  assign rise    = sync_now & ~sync_prev;
  assign fall    = ~sync_now & sync_prev;
  assign is_edge = (mode_i != SENSE_LVL_LOW);

  always_comb begin
    case (mode_i)
      SENSE_FALL: evt = fall;
      SENSE_RISE: evt = rise;
      SENSE_BOTH: evt = rise | fall;
      default:    evt = 1'b0;
    endcase
  end

  // An event outranks a simultaneous clear so that it is never lost.
  always_comb begin
    if (!is_edge) status_nxt = ~sync_now;
    else          status_nxt = evt | (status_o & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_o <= 1'b0;
    else        status_o <= status_nxt;
  end

  assert_clear_collision_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_edge && evt && clr_i) |=> status_o);

  assert_edge_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_edge && status_o && !clr_i) |=> status_o);

  assert_edge_only_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_edge && !status_o && !evt) |=> !status_o);

  assert_level_ignore_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_edge && !sync_now && clr_i) |=> status_o);

endmodule

// File: rtl/psu_regs.sv
module psu_regs
  import psu_pkg::*;
#(
  parameter int N_PINS = 8,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [N_PINS-1:0]   status_i,
  output logic [2*N_PINS-1:0] sense_o,
  output logic [N_PINS-1:0]   mask_o,
  output logic [N_PINS-1:0]   clr_o
);

  localparam int SENSE_W = 2 * N_PINS;

  logic hit_status, hit_sense, hit_mask;
  logic unused_wdata;

  assign hit_status = (bus_addr == ADDR_W'(OFS_STATUS));
  assign hit_sense  = (bus_addr == ADDR_W'(OFS_SENSE));
  assign hit_mask   = (bus_addr == ADDR_W'(OFS_MASK));
  assign unused_wdata = ^bus_wdata[DATA_W-1:SENSE_W];

  assign clr_o = {N_PINS{bus_wr & hit_status}} & ~bus_wdata[N_PINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_o <= '0;
      mask_o  <= '0;
    end else if (bus_wr) begin
      if (hit_sense) sense_o <= bus_wdata[SENSE_W-1:0];
      if (hit_mask)  mask_o  <= bus_wdata[N_PINS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (hit_status)     bus_rdata <= DATA_W'(status_i);
      else if (hit_sense) bus_rdata <= DATA_W'(sense_o);
      else if (hit_mask)  bus_rdata <= DATA_W'(mask_o);
      else                bus_rdata <= '0;
    end
  end

  assert_mask_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_mask) |=> (mask_o == $past(bus_wdata[N_PINS-1:0])));

  assert_sense_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_sense) |=> (sense_o == $past(bus_wdata[SENSE_W-1:0])));

  assert_unmapped_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit_status && !hit_sense && !hit_mask) |=> (bus_rdata == '0));

endmodule

// File: rtl/pin_sense_unit.sv
module pin_sense_unit
  import psu_pkg::*;
#(
  parameter int N_PINS = 8,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_PINS-1:0] irq_req_o
);

  logic [N_PINS-1:0]   sync_now, sync_prev, status_w, mask_w, clr_w;
  logic [2*N_PINS-1:0] sense_w;

  psu_regs #(.N_PINS(N_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .status_i  (status_w),
    .sense_o   (sense_w),
    .mask_o    (mask_w),
    .clr_o     (clr_w)
  );

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    psu_sync #(.IDLE_LVL(1'b1)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .d_i      (pin_i[g]),
      .q_o      (sync_now[g]),
      .q_prev_o (sync_prev[g])
    );

    psu_lane u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_now  (sync_now[g]),
      .sync_prev (sync_prev[g]),
      .mode_i    (sense_e'(sense_w[2*g+1:2*g])),
      .clr_i     (clr_w[g]),
      .status_o  (status_w[g])
    );
  end

  assign irq_req_o = status_w & ~mask_w;

  assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_req_o & mask_w) == '0));

endmodule

// File: tb/sim_pin_sense_unit.sv
module sim_pin_sense_unit;

  localparam int unsigned A_STATUS = 32'h10;
  localparam int unsigned A_SENSE  = 32'h14;
  localparam int unsigned A_MASK   = 32'h10010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins = 8'hFF;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [19:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pin_sense_unit u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pins),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wr(input int unsigned a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a[19:0]; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int unsigned a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a[19:0];
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 irq", {24'h0, irq}, 32'h0);
    rd(A_SENSE, d);  chk("R11 sense", d, 32'h0);
    rd(A_STATUS, d); chk("R11 status", d, 32'h0);
    rd(A_MASK, d);   chk("R11 mask", d, 32'h0);

    // R2 / R12 register access
    wr(A_SENSE, 32'h0000_E41B); rd(A_SENSE, d); chk("R2 sense rb", d, 32'h0000_E41B);
    wr(A_SENSE, 32'hFFFF_FFFF); rd(A_SENSE, d); chk("R2 sense upper", d, 32'h0000_FFFF);
    wr(A_MASK, 32'h0000_01A5);  rd(A_MASK, d);  chk("R10 mask rb", d, 32'h0000_00A5);
    rd(32'h18, d);    chk("R12 unmapped", d, 32'h0);
    rd(32'h10014, d); chk("R12 alias", d, 32'h0);
    wr(A_SENSE, 32'h0); wr(A_MASK, 32'h0);

    // R1 latency: pin 5 level-low
    pins[5] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 early", {24'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R1 arrive", {24'h0, irq}, 32'h20);
    pins[5] = 1'b1; settle();
    chk("R3 release", {24'h0, irq}, 32'h0);

    // Sweep every pin over every sense code
    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < 4; m++) begin
        string tg;
        logic [7:0] e;
        tg = (m == 0) ? "R3" : (m == 1) ? "R4" : (m == 2) ? "R5" : "R6";
        wr(A_SENSE, 32'(m) << (2 * p));
        wr(A_STATUS, 32'h0);
        chk({tg, " idle"}, {24'h0, irq}, 32'h0);
        pins[p] = 1'b0; settle();
        e = (m != 2) ? (8'h1 << p) : 8'h0;
        chk({tg, " fall"}, {24'h0, irq}, {24'h0, e});
        wr(A_STATUS, 32'hFF);
        chk("R7 write one", {24'h0, irq}, {24'h0, e});
        wr(A_STATUS, 32'h0);
        e = (m == 0) ? (8'h1 << p) : 8'h0;
        chk((m == 0) ? "R8 clr ignored" : "R7 clr", {24'h0, irq}, {24'h0, e});
        pins[p] = 1'b1; settle();
        e = (m >= 2) ? (8'h1 << p) : 8'h0;
        chk({tg, " rise"}, {24'h0, irq}, {24'h0, e});
        wr(A_STATUS, 32'h0);
      end
    end

    // R9 clear colliding with a fresh edge (pin 2, both edges)
    wr(A_SENSE, 32'h3 << 4);
    wr(A_STATUS, 32'h0);
    pins[2] = 1'b0; settle();
    chk("R9 armed", {24'h0, irq}, 32'h04);
    pins[2] = 1'b1;
    repeat (2) @(negedge clk);
    wr(A_STATUS, 32'h0);
    chk("R9 collision kept", {24'h0, irq}, 32'h04);
    wr(A_STATUS, 32'h0);
    chk("R9 later clear", {24'h0, irq}, 32'h0);

    // R10 exhaustive mask sweep with all status bits set
    wr(A_SENSE, 32'h0);
    pins = 8'h00; settle();
    rd(A_STATUS, d); chk("R12 status rd", d, 32'hFF);
    for (int mv = 0; mv < 256; mv++) begin
      wr(A_MASK, 32'(mv));
      chk("R10 mask", {24'h0, irq}, {24'h0, ~8'(mv)});
    end
    wr(A_MASK, 32'h0);
    pins = 8'hFF; settle();
    chk("R3 all released", {24'h0, irq}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule